// File: doc/BRIEF.md
# Function Unit with Encoded Select

This block is a purely combinational function unit. It takes two operands of a configurable width, `a_i` and `b_i`, and a 4-bit operation code `fs_i`. It returns one result `f_o` and four status flags: signed overflow, carry out, negative and zero. Inside, an adder/complement stage, a bitwise logic stage and a single-position shifter all run in parallel. An output mux then picks the arithmetic/logic result or the shifter result.

Every internal select comes from the same code, so no separate decoder is needed. The two top bits choose between the arithmetic, logic and shift groups. The shifter only ever acts on operand B. The fill bit that enters a vacated position is always zero. Code 1111 has no defined operation and drives an all-zero result.

Top module: `func_unit`

## Requirements
- R1: When fs_i[3] and fs_i[2] are both 1, f_o is the shifter result; otherwise f_o is the arithmetic or logic result.
- R2: Arithmetic codes (fs_i[3]=0) compute A + Y + fs_i[0] modulo 2^W, where fs_i[2:1] selects Y: 00 gives zero, 01 gives B, 10 gives ~B, and 11 gives all ones. The codes are 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A-B, 0110 A-1 and 0111 A.
- R3: Logic codes are 1000 A AND B, 1001 A OR B, 1010 A XOR B and 1011 NOT A.
- R4: Shift codes act on B: 1100 passes B unchanged, 1101 shifts right by one with a 0 entering the MSB, and 1110 shifts left by one with a 0 entering the LSB.
- R5: Code 1111 gives f_o equal to zero.
- R6: For arithmetic codes, c_o is bit W of the full sum A + Y + fs_i[0]. For every code with fs_i[3]=1, c_o is 0.
- R7: For arithmetic codes, v_o is 1 exactly when A and Y have the same sign bit and the result sign differs from it. For every code with fs_i[3]=1, v_o is 0.
- R8: n_o equals the most significant bit of f_o, for all codes.
- R9: z_o is 1 exactly when every bit of f_o is 0, for all codes.
- R10: The parameter DATA_W sets the operand width, and R1 to R9 hold at widths 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B, also the shifter input |
| fs_i | input | 4 | Operation code |
| f_o | output | DATA_W | Selected result |
| v_o | output | 1 | Signed overflow |
| c_o | output | 1 | Carry out |
| n_o | output | 1 | Result is negative |
| z_o | output | 1 | Result is zero |

## Verification
The bench builds two instances, one with DATA_W=8 and one with DATA_W=16. At width 8, a hand-computed vector table pins down the exact carry and overflow edges: 0x7F+1, 0xFF+1, 0x80-1 and A+all-ones+1. At both widths, random operands sweep all sixteen codes against an independent wide-integer model. The 16-bit instance shows that the flag positions and the shift fill follow the parameter and are not tied to bit 7.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int unsigned FS_W = 4;

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_NONE  = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } logic_e;

  typedef enum logic [1:0] {
    AY_ZERO = 2'b00,
    AY_B    = 2'b01,
    AY_NOTB = 2'b10,
    AY_ONES = 2'b11
  } addend_e;
endpackage

// File: rtl/fu_arith.sv
module fu_arith
  import fu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        sel_i,
  output logic [DATA_W-1:0] g_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] y;
  logic [DATA_W:0]   sum;
  addend_e           ysel;

  assign ysel = addend_e'(sel_i[2:1]);

  always_comb begin
    unique case (ysel)
      AY_ZERO: y = '0;
      AY_B:    y = b_i;
      AY_NOTB: y = ~b_i;
      default: y = '1;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, y} + {{DATA_W{1'b0}}, sel_i[0]};
  assign g_o = sum[MSB:0];
  assign c_o = sum[DATA_W];
  // overflow: like-signed inputs, result sign flipped
  assign v_o = (a_i[MSB] ~^ y[MSB]) & (g_o[MSB] ^ a_i[MSB]);

  always_comb begin
    // p_add_ovf_signs_r7
    if (sel_i == 3'b010 && v_o)
      assert (a_i[MSB] == b_i[MSB]) else $error("p_add_ovf_signs_r7");
    // p_pass_a_r2
    if (sel_i == 3'b000)
      assert (g_o == a_i && !c_o && !v_o) else $error("p_pass_a_r2");
  end
endmodule

// File: rtl/fu_logic.sv
module fu_logic
  import fu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] g_o
);
  logic_e op;
  assign op = logic_e'(sel_i);

  always_comb begin
    unique case (op)
      LG_AND:  g_o = a_i & b_i;
      LG_OR:   g_o = a_i | b_i;
      LG_XOR:  g_o = a_i ^ b_i;
      default: g_o = ~a_i;
    endcase
  end

  always_comb begin
    // p_xor_self_zero_r3
    if (op == LG_XOR && a_i == b_i)
      assert (g_o == '0) else $error("p_xor_self_zero_r3");
  end
endmodule

// File: rtl/fu_shift.sv
module fu_shift
  import fu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] h_o
);
  localparam int unsigned MSB = DATA_W - 1;
  shift_e op;
  assign op = shift_e'(sel_i);

  // per-bit mux, zero fill at both ends
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic from_hi, from_lo;
    if (i == MSB) begin : g_top
      assign from_hi = 1'b0;
    end else begin : g_top
      assign from_hi = b_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign from_lo = 1'b0;
    end else begin : g_bot
      assign from_lo = b_i[i-1];
    end
    always_comb begin
      unique case (op)
        SH_PASS:  h_o[i] = b_i[i];
        SH_RIGHT: h_o[i] = from_hi;
        SH_LEFT:  h_o[i] = from_lo;
        default:  h_o[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    // p_right_fill_r4
    if (op == SH_RIGHT) assert (!h_o[MSB]) else $error("p_right_fill_r4");
    // p_left_fill_r4
    if (op == SH_LEFT) assert (!h_o[0]) else $error("p_left_fill_r4");
    // p_ones_kept_r4
    if (op == SH_PASS)
      assert ($countones(h_o) == $countones(b_i)) else $error("p_ones_kept_r4");
  end
endmodule

// File: rtl/func_unit.sv
module func_unit
  import fu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FS_W-1:0]   fs_i,
  output logic [DATA_W-1:0] f_o,
  output logic              v_o,
  output logic              c_o,
  output logic              n_o,
  output logic              z_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] arith_g, logic_g, alu_g, shift_h;
  logic              arith_c, arith_v;
  logic              mf, is_logic;

  fu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(a_i), .b_i(b_i), .sel_i(fs_i[2:0]),
    .g_o(arith_g), .c_o(arith_c), .v_o(arith_v)
  );

  fu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(fs_i[1:0]), .g_o(logic_g)
  );

  fu_shift #(.DATA_W(DATA_W)) u_shift (
    .b_i(b_i), .sel_i(fs_i[1:0]), .h_o(shift_h)
  );

  assign is_logic = fs_i[3];
  assign mf       = fs_i[3] & fs_i[2];
  assign alu_g    = is_logic ? logic_g : arith_g;
  assign f_o      = mf ? shift_h : alu_g;
  assign c_o      = arith_c & ~is_logic;
  assign v_o      = arith_v & ~is_logic;
  assign n_o      = f_o[MSB];
  assign z_o      = ~|f_o;

  always_comb begin
    // p_flags_quiet_r6 / r7
    if (is_logic) assert (!c_o && !v_o) else $error("p_flags_quiet_r6");
    // p_unused_zero_r5
    if (fs_i == 4'hF) assert (z_o && !n_o) else $error("p_unused_zero_r5");
    // p_zero_not_neg_r9
    if (z_o) assert (!n_o) else $error("p_zero_not_neg_r9");
    // p_mf_shift_r1
    if (mf) assert (f_o == shift_h) else $error("p_mf_shift_r1");
  end
endmodule

// File: tb/func_unit_tb.sv
module func_unit_tb;
  localparam int NVEC = 18;
  // {fs, a, b, f, {v,c,n,z}} at width 8
  localparam logic [31:0] VEC [NVEC] = '{
    {4'h2, 8'h7F, 8'h01, 8'h80, 4'b1010},
    {4'h2, 8'hFF, 8'h01, 8'h00, 4'b0101},
    {4'h5, 8'h05, 8'h05, 8'h00, 4'b0101},
    {4'h5, 8'h80, 8'h01, 8'h7F, 4'b1100},
    {4'h1, 8'hFF, 8'h00, 8'h00, 4'b0101},
    {4'h6, 8'h00, 8'h00, 8'hFF, 4'b0010},
    {4'h0, 8'h5A, 8'h33, 8'h5A, 4'b0000},
    {4'h7, 8'h00, 8'h12, 8'h00, 4'b0101},
    {4'h8, 8'hF0, 8'h3C, 8'h30, 4'b0000},
    {4'h9, 8'hF0, 8'h0F, 8'hFF, 4'b0010},
    {4'hA, 8'hAA, 8'hAA, 8'h00, 4'b0001},
    {4'hB, 8'h00, 8'h55, 8'hFF, 4'b0010},
    {4'hC, 8'h00, 8'h81, 8'h81, 4'b0010},
    {4'hD, 8'h00, 8'h81, 8'h40, 4'b0000},
    {4'hE, 8'h00, 8'h81, 8'h02, 4'b0000},
    {4'hF, 8'hFF, 8'hFF, 8'h00, 4'b0001},
    {4'h4, 8'h03, 8'h01, 8'h01, 4'b0100},
    {4'h3, 8'h7F, 8'h00, 8'h80, 4'b1010}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0;

  logic [7:0]  a8, b8, f8;
  logic [15:0] a16, b16, f16;
  logic [3:0]  fs8, fs16;
  logic v8, c8, n8, z8, v16, c16, n16, z16;

  func_unit #(.DATA_W(8)) u_dut (
    .a_i(a8), .b_i(b8), .fs_i(fs8), .f_o(f8),
    .v_o(v8), .c_o(c8), .n_o(n8), .z_o(z8)
  );
  func_unit #(.DATA_W(16)) u_dut16 (
    .a_i(a16), .b_i(b16), .fs_i(fs16), .f_o(f16),
    .v_o(v16), .c_o(c16), .n_o(n16), .z_o(z16)
  );

  function automatic string req_of(input logic [3:0] fs);
    if (fs == 4'hF) return "R5";
    if (fs[3] & fs[2]) return "R1/R4";
    if (fs[3]) return "R3";
    return "R2";
  endfunction

  // independent wide model; result in [15:0], flags {v,c,n,z}
  task automatic model(input int w, input logic [3:0] fs, input logic [16:0] a,
                       input logic [16:0] b, output logic [16:0] f, output logic [3:0] fl);
    logic [16:0] mask, y, s;
    logic v, c;
    mask = (17'd1 << w) - 17'd1;
    v = 1'b0; c = 1'b0;
    if (!fs[3]) begin
      case (fs[2:1])
        2'd0: y = 17'd0;
        2'd1: y = b;
        2'd2: y = ~b & mask;
        default: y = mask;
      endcase
      s = a + y + {16'd0, fs[0]};
      c = s[w];
      f = s & mask;
      v = (a[w-1] == y[w-1]) && (f[w-1] != a[w-1]);
    end else if (!fs[2]) begin
      case (fs[1:0])
        2'd0: f = a & b;
        2'd1: f = a | b;
        2'd2: f = a ^ b;
        default: f = ~a & mask;
      endcase
    end else begin
      case (fs[1:0])
        2'd0: f = b;
        2'd1: f = b >> 1;
        2'd2: f = (b << 1) & mask;
        default: f = 17'd0;
      endcase
    end
    fl = {v, c, f[w-1], f == 17'd0};
  endtask

  task automatic check(input string req, input logic [15:0] got_f, input logic [3:0] got_fl,
                       input logic [15:0] exp_f, input logic [3:0] exp_fl);
    total++;
    if (got_f !== exp_f || got_fl !== exp_fl) begin
      bad++;
      $display("FAIL %s: f=%h flags=%b expected f=%h flags=%b", req, got_f, got_fl, exp_f, exp_fl);
    end
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog: hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [16:0] ef;
    logic [3:0]  efl;
    // initial state: all-zero inputs pass A=0, zero flag set (R2, R9)
    a8 = '0; b8 = '0; fs8 = '0; a16 = '0; b16 = '0; fs16 = '0;
    @(negedge clk);
    check("R9 init", {8'h0, f8}, {v8, c8, n8, z8}, 16'h0, 4'b0001);

    // directed table at width 8 (R2-R9)
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      {fs8, a8, b8} = VEC[i][31:12];
      @(negedge clk);
      check(req_of(fs8), {8'h0, f8}, {v8, c8, n8, z8}, {8'h0, VEC[i][11:4]}, VEC[i][3:0]);
    end

    // 16-bit corners: fill and flags at bit 15 (R10, R4, R7, R6)
    @(posedge clk); fs16 = 4'hD; b16 = 16'h8001; a16 = '0;
    @(negedge clk); check("R10 R4 right", f16, {v16, c16, n16, z16}, 16'h4000, 4'b0000);
    @(posedge clk); fs16 = 4'hE;
    @(negedge clk); check("R10 R4 left", f16, {v16, c16, n16, z16}, 16'h0002, 4'b0000);
    @(posedge clk); fs16 = 4'h2; a16 = 16'h7FFF; b16 = 16'h0001;
    @(negedge clk); check("R10 R7 ovf", f16, {v16, c16, n16, z16}, 16'h8000, 4'b1010);
    @(posedge clk); fs16 = 4'h2; a16 = 16'hFFFF; b16 = 16'h0001;
    @(negedge clk); check("R10 R6 carry", f16, {v16, c16, n16, z16}, 16'h0000, 4'b0101);
    @(posedge clk); fs16 = 4'hF; a16 = 16'hFFFF; b16 = 16'hFFFF;
    @(negedge clk); check("R10 R5 unused", f16, {v16, c16, n16, z16}, 16'h0000, 4'b0001);

    // random sweep at both widths against the model (R1-R10)
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      fs8  = 4'($urandom_range(0, 15));
      a8   = 8'($urandom);  b8  = 8'($urandom);
      fs16 = 4'($urandom_range(0, 15));
      a16  = 16'($urandom); b16 = 16'($urandom);
      @(negedge clk);
      model(8, fs8, {9'd0, a8}, {9'd0, b8}, ef, efl);
      check({req_of(fs8), " R8 R9 w8"}, {8'h0, f8}, {v8, c8, n8, z8}, ef[15:0], efl);
      model(16, fs16, {1'b0, a16}, {1'b0, b16}, ef, efl);
      check({req_of(fs16), " R10 w16"}, f16, {v16, c16, n16, z16}, ef[15:0], efl);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule